// File: doc/BRIEF.md
# Processor exception entry controller

This block decides, once per clock, whether a simple 32-bit core must leave its current program flow, and if so which cause wins. For the winning cause it forms a fixed word-aligned vector, moves the current status word into the saved-status slot of the target mode, switches the mode field, sets the interrupt masks and writes the banked link register. All of these updates happen in a single clock.

The same block carries the opposite path. When the core retires a PC write that has the status-restore flag set, the controller reloads the current status from the saved copy of the active mode and hands back the link value as the new PC. The core's own status writes (flag updates, mask changes) also arrive through this block. The core supplies the address of the instruction it is presenting and a word that may hold a trap instruction. The controller tells the core when to load its PC and with what value.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The PC target for an entry is four times the cause index: reset 0x00, undefined instruction 0x04, software trap 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C. No cause uses 0x14.
- R2: When several causes are pending in one cycle, the winner is picked in this order: reset, data abort, FIQ, IRQ, prefetch abort, undefined instruction, software trap. Undefined instruction wins over a trap in the same cycle.
- R3: A trap is taken only when `trap_i` is high and `instr_i[27:24]` equals 4'b1111. Otherwise the trap request is ignored. On a taken trap, `instr_i[23:0]` appears unchanged on `trap_num_o`, which holds it until the next trap.
- R4: On every non-reset entry, the saved status of the entered mode receives the status word as it stood before the entry.
- R5: Modes are encoded user 5'b10000, FIQ 5'b10001, IRQ 5'b10010, supervisor 5'b10011, abort 5'b10111 and undefined 5'b11011, with the IRQ mask at status bit 7 and the FIQ mask at bit 6. Trap and reset enter supervisor mode, both aborts enter abort mode, undefined enters undefined mode, IRQ enters IRQ mode and FIQ enters FIQ mode. Every entry sets the IRQ mask. Only FIQ and reset also set the FIQ mask; other entries leave it unchanged.
- R6: The banked link register of the entered mode receives the current instruction address with bits 1:0 cleared, plus 4. For a data abort the increment is 8 instead of 4.
- R7: An IRQ request is ignored while status bit 7 is set. An FIQ request is ignored while status bit 6 is set.
- R8: An exception return (`eret_i`) with no entry pending copies the saved status of the current mode into the status word. It also loads the PC with that mode's link value, bits 1:0 cleared. In user mode a return is ignored.
- R9: A reset entry, and the asynchronous reset, leave supervisor mode with both masks set. A reset entry saves no status and writes no link register.
- R10: `taken_o` is high for exactly the one cycle after an entry's clock edge. `pc_load_o` is high in that cycle and in the cycle after a return. `vec_o` holds its value between loads.
- R11: A status write (`stat_we_i`) replaces the status word only when neither an entry nor a return happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| rst_req_i | input | 1 | Reset cause request |
| und_i | input | 1 | Undefined-instruction flag |
| trap_i | input | 1 | Software-trap instruction flag |
| instr_i | input | 32 | Instruction word being executed |
| pabt_i | input | 1 | Prefetch abort flag |
| dabt_i | input | 1 | Data abort flag |
| irq_i | input | 1 | IRQ request line |
| fiq_i | input | 1 | FIQ request line |
| pc_i | input | 32 | Address of the current instruction |
| eret_i | input | 1 | PC write with status restore |
| stat_we_i | input | 1 | Core writes the status word |
| stat_wdata_i | input | 32 | Status word write data |
| taken_o | output | 1 | Entry performed, one-cycle pulse |
| pc_load_o | output | 1 | Core loads its PC from `vec_o` |
| vec_o | output | 32 | Vector or return address |
| mode_o | output | 5 | Current mode field |
| irq_mask_o | output | 1 | Current IRQ mask |
| fiq_mask_o | output | 1 | Current FIQ mask |
| lr_o | output | 32 | Banked link register of the current mode, zero in user mode |
| spsr_o | output | 32 | Saved status of the current mode, zero in user mode |
| trap_num_o | output | 24 | Comment field of the last taken trap |

## Verification
The bench stacks causes in the same cycle: data abort with FIQ, FIQ with IRQ, prefetch abort with undefined, undefined with trap, and reset with everything. An arbiter with the wrong order would show the wrong vector and mode. It raises IRQ while already inside the IRQ handler and FIQ while bit 6 is set. A controller that ignored the masks would take a nested entry and overwrite the saved status of the handler. A trap word whose bits 27:24 are not all ones must leave the flow alone. A trap from an unaligned address must produce a link value with bits 1:0 cleared. Returns are checked to restore the pre-entry mode and masks, and a return in user mode must not load the PC.

// File: rtl/exc_pkg.sv
package exc_pkg;

  localparam int XLEN   = 32;
  localparam int MODE_W = 5;
  localparam int NBANK  = 5;
  localparam int BSEL_W = $clog2(NBANK);
  localparam int IMASK_BIT = 7;
  localparam int FMASK_BIT = 6;
  localparam int TRAP_NUM_W = 24;

  // cause index doubles as the vector slot number
  typedef enum logic [2:0] {
    C_RST  = 3'd0,
    C_UND  = 3'd1,
    C_TRAP = 3'd2,
    C_PABT = 3'd3,
    C_DABT = 3'd4,
    C_RSVD = 3'd5,
    C_IRQ  = 3'd6,
    C_FIQ  = 3'd7
  } cause_e;

  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;

  function automatic logic [BSEL_W-1:0] bank_sel(input logic [MODE_W-1:0] m);
    case (m)
      M_FIQ:   bank_sel = BSEL_W'(0);
      M_IRQ:   bank_sel = BSEL_W'(1);
      M_SVC:   bank_sel = BSEL_W'(2);
      M_ABT:   bank_sel = BSEL_W'(3);
      M_UND:   bank_sel = BSEL_W'(4);
      default: bank_sel = BSEL_W'(0);
    endcase
  endfunction

  function automatic logic bank_has(input logic [MODE_W-1:0] m);
    bank_has = (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
               (m == M_ABT) || (m == M_UND);
  endfunction

endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb
  import exc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   rst_req_i,
  input  logic   dabt_i,
  input  logic   fiq_i,
  input  logic   irq_i,
  input  logic   pabt_i,
  input  logic   und_i,
  input  logic   trap_ok_i,
  input  logic   imask_i,
  input  logic   fmask_i,
  output logic   valid_o,
  output cause_e cause_o
);

  localparam int NREQ = 7;

  logic   [NREQ-1:0] req;
  cause_e            slot_cause [NREQ];
  logic   [NREQ:0]   seen;
  logic   [NREQ-1:0] gnt;
  logic   [2:0]      cause_or;

  // slot 0 is the highest priority
  always_comb begin
    req[0] = rst_req_i;
    req[1] = dabt_i;
    req[2] = fiq_i & ~fmask_i;
    req[3] = irq_i & ~imask_i;
    req[4] = pabt_i;
    req[5] = und_i;
    req[6] = trap_ok_i;
    slot_cause[0] = C_RST;
    slot_cause[1] = C_DABT;
    slot_cause[2] = C_FIQ;
    slot_cause[3] = C_IRQ;
    slot_cause[4] = C_PABT;
    slot_cause[5] = C_UND;
    slot_cause[6] = C_TRAP;
  end

  assign seen[0] = 1'b0;

  genvar k;
  generate
    for (k = 0; k < NREQ; k++) begin : g_chain
      assign gnt[k]    = req[k] & ~seen[k];
      assign seen[k+1] = seen[k] | req[k];
    end
  endgenerate

  always_comb begin
    cause_or = 3'd0;
    for (int j = 0; j < NREQ; j++) begin
      if (gnt[j]) cause_or = cause_or | slot_cause[j];
    end
  end

  assign valid_o = seen[NREQ];
  assign cause_o = cause_e'(cause_or);

  // R2: at most one winner per cycle
  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R7: a masked IRQ never wins
  a_r7_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cause_o == C_IRQ) |-> !imask_i);

  // R7: a masked FIQ never wins
  a_r7_fiq_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cause_o == C_FIQ) |-> !fmask_i);

endmodule

// File: rtl/exc_entry_decode.sv
module exc_entry_decode
  import exc_pkg::*;
(
  input  cause_e            cause_i,
  output logic [MODE_W-1:0] mode_o,
  output logic              set_f_o,
  output logic              save_o,
  output logic [XLEN-1:0]   link_off_o,
  output logic [XLEN-1:0]   vec_o
);

  always_comb begin
    set_f_o    = 1'b0;
    save_o     = 1'b1;
    link_off_o = XLEN'(4);
    case (cause_i)
      C_RST: begin
        mode_o  = M_SVC;
        set_f_o = 1'b1;
        save_o  = 1'b0;
      end
      C_UND:  mode_o = M_UND;
      C_TRAP: mode_o = M_SVC;
      C_PABT: mode_o = M_ABT;
      C_DABT: begin
        mode_o     = M_ABT;
        link_off_o = XLEN'(8);
      end
      C_IRQ:  mode_o = M_IRQ;
      C_FIQ: begin
        mode_o  = M_FIQ;
        set_f_o = 1'b1;
      end
      default: mode_o = M_SVC;
    endcase
  end

  // word slot per cause
  assign vec_o = {{(XLEN-5){1'b0}}, cause_i, 2'b00};

endmodule

// File: rtl/exc_bank_file.sv
module exc_bank_file
  import exc_pkg::*;
#(
  parameter int W  = XLEN,
  parameter int NB = NBANK,
  localparam int SW = (NB > 1) ? $clog2(NB) : 1
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spsr_we_i,
  input  logic          lr_we_i,
  input  logic [SW-1:0] wr_sel_i,
  input  logic [W-1:0]  spsr_wd_i,
  input  logic [W-1:0]  lr_wd_i,
  input  logic [SW-1:0] rd_sel_i,
  input  logic          rd_ok_i,
  output logic [W-1:0]  spsr_rd_o,
  output logic [W-1:0]  lr_rd_o
);

  logic [NB-1:0][W-1:0] spsr_all;
  logic [NB-1:0][W-1:0] lr_all;

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_bank
      logic [W-1:0] spsr_q, spsr_d;
      logic [W-1:0] lr_q, lr_d;
      logic         hit;

      assign hit = (wr_sel_i == SW'(b));

      always_comb begin
        spsr_d = spsr_q;
        lr_d   = lr_q;
        if (spsr_we_i && hit) spsr_d = spsr_wd_i;
        if (lr_we_i && hit)   lr_d   = lr_wd_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          spsr_q <= '0;
          lr_q   <= '0;
        end else begin
          spsr_q <= spsr_d;
          lr_q   <= lr_d;
        end
      end

      assign spsr_all[b] = spsr_q;
      assign lr_all[b]   = lr_q;
    end
  endgenerate

  assign spsr_rd_o = rd_ok_i ? spsr_all[rd_sel_i] : '0;
  assign lr_rd_o   = rd_ok_i ? lr_all[rd_sel_i]   : '0;

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rst_req_i,
  input  logic                  und_i,
  input  logic                  trap_i,
  input  logic [31:0]           instr_i,
  input  logic                  pabt_i,
  input  logic                  dabt_i,
  input  logic                  irq_i,
  input  logic                  fiq_i,
  input  logic [31:0]           pc_i,
  input  logic                  eret_i,
  input  logic                  stat_we_i,
  input  logic [31:0]           stat_wdata_i,
  output logic                  taken_o,
  output logic                  pc_load_o,
  output logic [31:0]           vec_o,
  output logic [4:0]            mode_o,
  output logic                  irq_mask_o,
  output logic                  fiq_mask_o,
  output logic [31:0]           lr_o,
  output logic [31:0]           spsr_o,
  output logic [23:0]           trap_num_o
);

  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);
  localparam logic [XLEN-1:0] STAT_RST =
    XLEN'((1 << IMASK_BIT) | (1 << FMASK_BIT)) | XLEN'(M_SVC);

  logic [XLEN-1:0]       cpsr_q, cpsr_d;
  logic [XLEN-1:0]       vec_q, vec_d;
  logic                  taken_q, taken_d;
  logic                  load_q, load_d;
  logic [TRAP_NUM_W-1:0] tnum_q, tnum_d;
  logic                  vec_en, tnum_en;

  logic                  trap_ok;
  logic                  gnt_valid;
  cause_e                gnt_cause;
  logic [MODE_W-1:0]     new_mode;
  logic                  new_set_f;
  logic                  new_save;
  logic [XLEN-1:0]       link_off;
  logic [XLEN-1:0]       vec_slot;

  logic                  bank_spsr_we, bank_lr_we;
  logic [BSEL_W-1:0]     bank_wsel, bank_rsel;
  logic                  bank_rok;
  logic [XLEN-1:0]       spsr_rd, lr_rd;

  assign trap_ok = trap_i && (instr_i[27:24] == 4'b1111);

  exc_prio_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_req_i (rst_req_i),
    .dabt_i    (dabt_i),
    .fiq_i     (fiq_i),
    .irq_i     (irq_i),
    .pabt_i    (pabt_i),
    .und_i     (und_i),
    .trap_ok_i (trap_ok),
    .imask_i   (cpsr_q[IMASK_BIT]),
    .fmask_i   (cpsr_q[FMASK_BIT]),
    .valid_o   (gnt_valid),
    .cause_o   (gnt_cause)
  );

  exc_entry_decode u_dec (
    .cause_i    (gnt_cause),
    .mode_o     (new_mode),
    .set_f_o    (new_set_f),
    .save_o     (new_save),
    .link_off_o (link_off),
    .vec_o      (vec_slot)
  );

  assign bank_rsel = bank_sel(cpsr_q[MODE_W-1:0]);
  assign bank_rok  = bank_has(cpsr_q[MODE_W-1:0]);
  assign bank_wsel = bank_sel(new_mode);

  exc_bank_file #(.W(XLEN), .NB(NBANK)) u_banks (
    .clk       (clk),
    .rst_n     (rst_n),
    .spsr_we_i (bank_spsr_we),
    .lr_we_i   (bank_lr_we),
    .wr_sel_i  (bank_wsel),
    .spsr_wd_i (cpsr_q),
    .lr_wd_i   ((pc_i & ALIGN_MASK) + link_off),
    .rd_sel_i  (bank_rsel),
    .rd_ok_i   (bank_rok),
    .spsr_rd_o (spsr_rd),
    .lr_rd_o   (lr_rd)
  );

  // next-state: entry over return over status write
  always_comb begin
    cpsr_d       = cpsr_q;
    vec_d        = vec_q;
    taken_d      = 1'b0;
    load_d       = 1'b0;
    tnum_d       = tnum_q;
    bank_spsr_we = 1'b0;
    bank_lr_we   = 1'b0;
    if (gnt_valid) begin
      taken_d = 1'b1;
      load_d  = 1'b1;
      vec_d   = vec_slot;
      cpsr_d[MODE_W-1:0] = new_mode;
      cpsr_d[IMASK_BIT]  = 1'b1;
      if (new_set_f) cpsr_d[FMASK_BIT] = 1'b1;
      bank_spsr_we = new_save;
      bank_lr_we   = new_save;
      if (gnt_cause == C_TRAP) tnum_d = instr_i[TRAP_NUM_W-1:0];
    end else if (eret_i && bank_rok) begin
      load_d = 1'b1;
      vec_d  = lr_rd & ALIGN_MASK;
      cpsr_d = spsr_rd;
    end else if (stat_we_i) begin
      cpsr_d = stat_wdata_i;
    end
  end

  assign vec_en  = load_d;
  assign tnum_en = gnt_valid && (gnt_cause == C_TRAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpsr_q  <= STAT_RST;
      vec_q   <= '0;
      taken_q <= 1'b0;
      load_q  <= 1'b0;
      tnum_q  <= '0;
    end else begin
      cpsr_q  <= cpsr_d;
      taken_q <= taken_d;
      load_q  <= load_d;
      if (vec_en)  vec_q  <= vec_d;
      if (tnum_en) tnum_q <= tnum_d;
    end
  end

  assign taken_o    = taken_q;
  assign pc_load_o  = load_q;
  assign vec_o      = vec_q;
  assign mode_o     = cpsr_q[MODE_W-1:0];
  assign irq_mask_o = cpsr_q[IMASK_BIT];
  assign fiq_mask_o = cpsr_q[FMASK_BIT];
  assign lr_o       = lr_rd;
  assign spsr_o     = spsr_rd;
  assign trap_num_o = tnum_q;

  // R10: every entry is also a PC load
  a_r10_taken_loads: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> pc_load_o);

  // R9: a reset request lands in supervisor mode with both masks set at slot 0
  a_r9_reset_entry: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_i |=> (taken_o && mode_o == M_SVC && irq_mask_o && fiq_mask_o
                   && vec_o == '0));

  // R4: non-reset entry saved the pre-entry status
  a_r4_status_saved: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !rst_req_i && gnt_valid) |=> (spsr_o == $past(cpsr_q)));

  // R6: link value for word-step causes
  a_r6_link_value: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && gnt_cause != C_RST && gnt_cause != C_DABT)
      |=> (lr_o == (($past(pc_i) & ALIGN_MASK) + XLEN'(4))));

  // R1 / R10: vector outputs are always word aligned
  a_r1_vec_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load_o |-> (vec_o[1:0] == 2'b00));

  // R8: a return takes the mode held in the saved copy
  a_r8_return_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid && eret_i && bank_rok) |=>
      (pc_load_o && !taken_o && mode_o == $past(spsr_rd[MODE_W-1:0])));

endmodule

// File: tb/exc_entry_ctrl_tb_top.sv
module exc_entry_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        rst_req_i, und_i, trap_i, pabt_i, dabt_i, irq_i, fiq_i;
  logic        eret_i, stat_we_i;
  logic [31:0] instr_i, pc_i, stat_wdata_i;
  logic        taken_o, pc_load_o, irq_mask_o, fiq_mask_o;
  logic [31:0] vec_o, lr_o, spsr_o;
  logic [4:0]  mode_o;
  logic [23:0] trap_num_o;

  exc_entry_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req_i), .und_i(und_i),
    .trap_i(trap_i), .instr_i(instr_i), .pabt_i(pabt_i), .dabt_i(dabt_i),
    .irq_i(irq_i), .fiq_i(fiq_i), .pc_i(pc_i), .eret_i(eret_i),
    .stat_we_i(stat_we_i), .stat_wdata_i(stat_wdata_i),
    .taken_o(taken_o), .pc_load_o(pc_load_o), .vec_o(vec_o),
    .mode_o(mode_o), .irq_mask_o(irq_mask_o), .fiq_mask_o(fiq_mask_o),
    .lr_o(lr_o), .spsr_o(spsr_o), .trap_num_o(trap_num_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    string       tag;
    logic        taken;
    logic        load;
    logic [31:0] vec;
    logic [4:0]  mode;
    logic        im;
    logic        fm;
    logic [31:0] lr;
    logic [31:0] spsr;
    logic [23:0] tnum;
  } exp_t;

  exp_t        sb_q[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic        done = 1'b0;

  // reference state built from the requirements
  logic [31:0] st_m;
  logic [31:0] sv_m [5];
  logic [31:0] ln_m [5];
  logic [31:0] vec_m;
  logic [23:0] tn_m;

  function automatic int bidx(input logic [4:0] m);
    case (m)
      5'b10001: return 0;
      5'b10010: return 1;
      5'b10011: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  function automatic logic [4:0] mode_of(input int c);
    case (c)
      0, 2:    return 5'b10011;
      1:       return 5'b11011;
      3, 4:    return 5'b10111;
      6:       return 5'b10010;
      default: return 5'b10001;
    endcase
  endfunction

  task automatic apply(input string tag, input logic rq, input logic ud,
                       input logic tp, input logic [31:0] ins,
                       input logic pa, input logic da, input logic iq,
                       input logic fq, input logic rt, input logic sw,
                       input logic [31:0] swd, input logic [31:0] pc);
    exp_t e;
    int   c;
    int   b;
    logic [31:0] s;
    @(negedge clk);
    rst_req_i = rq; und_i = ud; trap_i = tp; instr_i = ins; pabt_i = pa;
    dabt_i = da; irq_i = iq; fiq_i = fq; eret_i = rt; stat_we_i = sw;
    stat_wdata_i = swd; pc_i = pc;
    @(posedge clk);
    #1;
    s = st_m;
    e.taken = 1'b0;
    e.load  = 1'b0;
    if (rq)                    c = 0;
    else if (da)               c = 4;
    else if (fq && !s[6])      c = 7;
    else if (iq && !s[7])      c = 6;
    else if (pa)               c = 3;
    else if (ud)               c = 1;
    else if (tp && ins[27:24] == 4'b1111) c = 2;
    else                       c = -1;
    if (c >= 0) begin
      if (c != 0) begin
        b = bidx(mode_of(c));
        sv_m[b] = s;
        ln_m[b] = (pc & ~32'h3) + ((c == 4) ? 32'd8 : 32'd4);
      end
      s[4:0] = mode_of(c);
      s[7]   = 1'b1;
      if (c == 0 || c == 7) s[6] = 1'b1;
      vec_m = 32'(c * 4);
      if (c == 2) tn_m = ins[23:0];
      e.taken = 1'b1;
      e.load  = 1'b1;
    end else if (rt && bidx(s[4:0]) >= 0) begin
      b = bidx(s[4:0]);
      vec_m  = ln_m[b] & ~32'h3;
      s      = sv_m[b];
      e.load = 1'b1;
    end else if (sw) begin
      s = swd;
    end
    st_m   = s;
    e.tag  = tag;
    e.vec  = vec_m;
    e.mode = s[4:0];
    e.im   = s[7];
    e.fm   = s[6];
    b      = bidx(s[4:0]);
    e.lr   = (b >= 0) ? ln_m[b] : 32'h0;
    e.spsr = (b >= 0) ? sv_m[b] : 32'h0;
    e.tnum = tn_m;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    apply("idle", 0,0,0,32'h0,0,0,0,0,0,0,32'h0,32'h0);
  endtask

  // monitor: compares the design against queued expectations
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      while (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        n_chk++;
        if (taken_o !== e.taken || pc_load_o !== e.load || vec_o !== e.vec ||
            mode_o !== e.mode || irq_mask_o !== e.im || fiq_mask_o !== e.fm ||
            lr_o !== e.lr || spsr_o !== e.spsr || trap_num_o !== e.tnum) begin
          n_bad++;
          $display("FAIL %s: got tk=%b ld=%b vec=%h md=%b I=%b F=%b lr=%h sp=%h tn=%h exp tk=%b ld=%b vec=%h md=%b I=%b F=%b lr=%h sp=%h tn=%h",
                   e.tag, taken_o, pc_load_o, vec_o, mode_o, irq_mask_o,
                   fiq_mask_o, lr_o, spsr_o, trap_num_o, e.taken, e.load,
                   e.vec, e.mode, e.im, e.fm, e.lr, e.spsr, e.tnum);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    rst_req_i = 0; und_i = 0; trap_i = 0; instr_i = '0; pabt_i = 0;
    dabt_i = 0; irq_i = 0; fiq_i = 0; eret_i = 0; stat_we_i = 0;
    stat_wdata_i = '0; pc_i = '0;
    st_m = 32'hD3; vec_m = '0; tn_m = '0;
    for (int i = 0; i < 5; i++) begin sv_m[i] = '0; ln_m[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: state after asynchronous reset
    n_chk++;
    if (taken_o !== 1'b0 || pc_load_o !== 1'b0 || mode_o !== 5'b10011 ||
        irq_mask_o !== 1'b1 || fiq_mask_o !== 1'b1) begin
      n_bad++;
      $display("FAIL R9 reset state: got tk=%b ld=%b md=%b I=%b F=%b exp tk=0 ld=0 md=10011 I=1 F=1",
               taken_o, pc_load_o, mode_o, irq_mask_o, fiq_mask_o);
    end
    //        tag                       rq ud tp ins           pa da iq fq rt sw swd           pc
    apply("R11 status write to user",   0,0,0,32'h0,        0,0,0,0,0,1,32'hA000_0010,32'h0);
    apply("R3 R4 R5 R6 trap entry",     0,0,1,32'hEF00_1234,0,0,0,0,0,0,32'h0,32'h0000_0100);
    apply("R8 return from trap",        0,0,0,32'h0,        0,0,0,0,1,0,32'h0,32'h0);
    apply("R3 malformed trap ignored",  0,0,1,32'hEE00_5555,0,0,0,0,0,0,32'h0,32'h0000_0200);
    apply("R1 R5 R6 IRQ entry",         0,0,0,32'h0,        0,0,1,0,0,0,32'h0,32'h0000_0300);
    apply("R7 IRQ while masked",        0,0,0,32'h0,        0,0,1,0,0,0,32'h0,32'h0000_0400);
    apply("R11 status write lost to return", 0,0,0,32'h0,   0,0,0,0,1,1,32'h0000_00D3,32'h0);
    apply("R2 FIQ over IRQ",            0,0,0,32'h0,        0,0,1,1,0,0,32'h0,32'h0000_0500);
    apply("R8 return from FIQ",         0,0,0,32'h0,        0,0,0,0,1,0,32'h0,32'h0);
    apply("R2 R6 data abort over FIQ",  0,0,0,32'h0,        0,1,0,1,0,0,32'h0,32'h0000_0600);
    apply("R8 return from abort",       0,0,0,32'h0,        0,0,0,0,1,0,32'h0,32'h0);
    apply("R2 prefetch over undefined", 0,1,0,32'h0,        1,0,0,0,0,0,32'h0,32'h0000_0700);
    apply("R8 return from prefetch",    0,0,0,32'h0,        0,0,0,0,1,0,32'h0,32'h0);
    apply("R2 undefined over trap",     0,1,1,32'hEF00_0077,0,0,0,0,0,0,32'h0,32'h0000_0800);
    apply("R8 return from undefined",   0,0,0,32'h0,        0,0,0,0,1,0,32'h0,32'h0);
    apply("R6 unaligned trap address",  0,0,1,32'h0FAB_CDEF,0,0,0,0,0,0,32'h0,32'h0000_0203);
    apply("R8 return to unaligned",     0,0,0,32'h0,        0,0,0,0,1,0,32'h0,32'h0);
    apply("R8 return in user ignored",  0,0,0,32'h0,        0,0,0,0,1,0,32'h0,32'h0);
    apply("R11 set FIQ mask",           0,0,0,32'h0,        0,0,0,0,0,1,32'h0000_0050,32'h0);
    apply("R7 FIQ while masked",        0,0,0,32'h0,        0,0,0,1,0,0,32'h0,32'h0000_0900);
    apply("R9 R2 reset beats all",      1,1,1,32'hEF00_0001,1,1,1,1,1,1,32'h0,32'h0000_0A00);
    apply("R10 pulse ends",             0,0,0,32'h0,        0,0,0,0,0,0,32'h0,32'h0);
    idle();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule